// File: doc/BRIEF.md
# Polled Transmit Space-Available Responder

This block produces the transmit flow-control flag for one port that shares a polled multi-port bus with other ports. It keeps a count of the bytes held in the port's transmit FIFO. It does this from two single-byte strobes: one pulses when a byte enters the FIFO and one pulses when a byte leaves it. From that count it decides whether the upstream side may send more. In cell mode the decision is "room for one more whole cell". In packet mode it is "room for at least a programmed number of bytes". The FIFO storage itself, the framing and the line side are outside this block.

The bus master polls the ports by placing a 5-bit address on a shared bus. The flag pin is modelled as a status bit plus a drive enable. The enable goes high a fixed number of cycles after the poll address matches this port's assigned address, and it goes low again with the same delay once the address moves away. Enable low means the pin is released. The delay is one cycle for cell mode and for packet mode at the lower polling level. It is two cycles for packet mode at the higher polling level. All pins are plain control and status signals. The strobes carry no back-pressure: the caller must not pulse the write strobe when the flag says there is no room.

Top module: `txsr_space_responder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the fill count to zero and drives `space_oe` low on the following cycle.
- R2: At each rising edge the fill count moves as follows. A write strobe alone adds one. A read strobe alone subtracts one. Both strobes together leave it unchanged.
- R3: A lone write strobe while the count equals `DEPTH` is ignored. A lone read strobe while the count is zero is ignored.
- R4: With `mode_pkt` = 0 (cell mode), `space_ok` is 1 exactly when `DEPTH` minus the fill count is at least `CELL_BYTES` (default 256 and 53).
- R5: With `mode_pkt` = 1 (packet mode), `space_ok` is 1 exactly when `DEPTH` minus the fill count is at least `pkt_need`.
- R6: The port counts as addressed when `poll_addr` equals `port_addr` and is not 5'h1F. The value 5'h1F never produces a match, even when `port_addr` is 5'h1F.
- R7: When not (`mode_pkt` = 1 and `level3_sel` = 1), `space_oe` in each cycle equals the address-match result of the previous cycle. This applies to both assertion and release.
- R8: When `mode_pkt` = 1 and `level3_sel` = 1, `space_oe` equals the address-match result of two cycles earlier. This applies to both assertion and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pkt | input | 1 | 0 = cell mode, 1 = packet mode |
| level3_sel | input | 1 | 1 = higher polling level (two-cycle enable delay in packet mode) |
| port_addr | input | 5 | Address assigned to this port |
| poll_addr | input | 5 | Address currently polled by the bus master |
| wr_byte | input | 1 | One byte written into the transmit FIFO |
| rd_byte | input | 1 | One byte removed from the transmit FIFO |
| pkt_need | input | $clog2(DEPTH+1) | Free-byte threshold used in packet mode |
| space_ok | output | 1 | Space-available flag value |
| space_oe | output | 1 | Drive enable for the flag; low means released |

## Verification
The bound checker checks the following on every cycle: the fill count moves by at most one in the direction the strobes ask, stays still under both strobes, and pins at the full and empty ends. It also checks that the flag matches the mode's threshold rule and that the drive enable follows the match history with the delay the mode selects. The following behaviours only show up in the bench's scenarios: a full fill to capacity and a drain past empty, the threshold being reprogrammed mid-run, the null address assigned as the port's own address, and mode switches that change the enable delay while polling continues. The bench's reference model follows every one of those cycles.

// File: rtl/txsr_pkg.sv
`timescale 1ns/1ps
package txsr_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 5'h1F;
  localparam int MAX_POLL_LAT = 2;

  typedef enum logic {
    IF_CELL   = 1'b0,
    IF_PACKET = 1'b1
  } if_mode_e;
endpackage

// File: rtl/txsr_fill_tracker.sv
`timescale 1ns/1ps
module txsr_fill_tracker #(
  parameter int DEPTH = 256,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic             rd_stb,
  output logic [OCC_W-1:0] fill
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic is_full, is_empty;
  assign is_full  = (fill == FULL);
  assign is_empty = (fill == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
    end else if (wr_stb && !rd_stb && !is_full) begin
      fill <= fill + 1'b1;
    end else if (rd_stb && !wr_stb && !is_empty) begin
      fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/txsr_space_judge.sv
`timescale 1ns/1ps
module txsr_space_judge
  import txsr_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int CELL_BYTES = 53,
  parameter int OCC_W      = $clog2(DEPTH + 1)
) (
  input  logic [OCC_W-1:0] fill,
  input  if_mode_e         mode,
  input  logic [OCC_W-1:0] pkt_need,
  output logic             space_ok
);
  localparam logic [OCC_W-1:0] FULL    = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] CELL_LV = OCC_W'(CELL_BYTES);

  logic [OCC_W-1:0] free_bytes;
  logic [OCC_W-1:0] need;

  always_comb begin
    free_bytes = FULL - fill;
    need       = (mode == IF_PACKET) ? pkt_need : CELL_LV;
    space_ok   = (free_bytes >= need);
  end
endmodule

// File: rtl/txsr_poll_delay.sv
`timescale 1ns/1ps
module txsr_poll_delay
  import txsr_pkg::*;
#(
  parameter int LAT = MAX_POLL_LAT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              slow,
  output logic              oe
);
  logic           hit;
  logic [LAT-1:0] stage;

  assign hit = (poll_addr == port_addr) && (poll_addr != NULL_ADDR);

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= hit;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= 1'b0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign oe = slow ? stage[LAT-1] : stage[0];
endmodule

// File: rtl/txsr_space_responder.sv
`timescale 1ns/1ps
module txsr_space_responder
  import txsr_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int CELL_BYTES = 53,
  localparam int OCC_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pkt,
  input  logic             level3_sel,
  input  logic [4:0]       port_addr,
  input  logic [4:0]       poll_addr,
  input  logic             wr_byte,
  input  logic             rd_byte,
  input  logic [OCC_W-1:0] pkt_need,
  output logic             space_ok,
  output logic             space_oe
);
  logic [OCC_W-1:0] fill;
  if_mode_e         mode;
  logic             slow;

  assign mode = if_mode_e'(mode_pkt);
  assign slow = (mode == IF_PACKET) && level3_sel;

  txsr_fill_tracker #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_fill (
    .clk(clk), .rst(rst), .wr_stb(wr_byte), .rd_stb(rd_byte), .fill(fill)
  );

  txsr_space_judge #(.DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES), .OCC_W(OCC_W)) u_judge (
    .fill(fill), .mode(mode), .pkt_need(pkt_need), .space_ok(space_ok)
  );

  txsr_poll_delay #(.LAT(MAX_POLL_LAT)) u_poll (
    .clk(clk), .rst(rst), .poll_addr(poll_addr), .port_addr(port_addr),
    .slow(slow), .oe(space_oe)
  );
endmodule

// File: rtl/txsr_checker.sv
`timescale 1ns/1ps
module txsr_checker #(
  parameter int DEPTH      = 256,
  parameter int CELL_BYTES = 53,
  parameter int OCC_W      = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_pkt,
  input logic             level3_sel,
  input logic [4:0]       port_addr,
  input logic [4:0]       poll_addr,
  input logic             wr_byte,
  input logic             rd_byte,
  input logic [OCC_W-1:0] pkt_need,
  input logic             space_ok,
  input logic             space_oe,
  input logic [OCC_W-1:0] fill
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic [1:0] since;
  logic       addr_hit;
  logic       slow_sel;

  assign addr_hit = (poll_addr == port_addr) && (poll_addr != 5'h1F);
  assign slow_sel = mode_pkt && level3_sel;

  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (fill == '0 && !space_oe)); // R1
  AST_HOLD_BOTH: assert property (@(posedge clk) disable iff (rst)
    (wr_byte && rd_byte) |=> $stable(fill)); // R2
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_byte && !rd_byte && fill != FULL) |=> fill == $past(fill) + 1'b1); // R2
  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_byte && !wr_byte && fill != '0) |=> fill == $past(fill) - 1'b1); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_byte && !rd_byte && fill == FULL) |=> fill == FULL); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_byte && !wr_byte && fill == '0) |=> fill == '0); // R3
  AST_CELL_FLAG: assert property (@(posedge clk) disable iff (rst)
    !mode_pkt |-> space_ok == ((FULL - fill) >= OCC_W'(CELL_BYTES))); // R4
  AST_PKT_FLAG: assert property (@(posedge clk) disable iff (rst)
    mode_pkt |-> space_ok == ((FULL - fill) >= pkt_need)); // R5
  AST_NULL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && $past(poll_addr) == 5'h1F && $past(poll_addr, 2) == 5'h1F) |-> !space_oe); // R6
  AST_FAST_LAT: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd1 && !slow_sel) |-> space_oe == $past(addr_hit)); // R7
  AST_SLOW_LAT: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && slow_sel) |-> space_oe == $past(addr_hit, 2)); // R8
endmodule

bind txsr_space_responder txsr_checker #(
  .DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES), .OCC_W(OCC_W)
) chk_i (
  .clk(clk), .rst(rst), .mode_pkt(mode_pkt), .level3_sel(level3_sel),
  .port_addr(port_addr), .poll_addr(poll_addr), .wr_byte(wr_byte),
  .rd_byte(rd_byte), .pkt_need(pkt_need), .space_ok(space_ok),
  .space_oe(space_oe), .fill(fill)
);

// File: tb/txsr_space_responder_tb_top.sv
`timescale 1ns/1ps
module txsr_space_responder_tb_top;
  localparam int DEPTH = 256;
  localparam int CELL  = 53;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pkt = 1'b0, level3_sel = 1'b0;
  logic [4:0] port_addr = 5'd7, poll_addr = 5'h1F;
  logic wr_byte = 1'b0, rd_byte = 1'b0;
  logic [OCC_W-1:0] pkt_need = '0;
  logic space_ok, space_oe;

  int errors = 0;
  int checks = 0;
  bit live = 1'b0;
  string scen = "R1";

  always #4 clk = ~clk;

  txsr_space_responder #(.DEPTH(DEPTH), .CELL_BYTES(CELL)) dut_i (
    .clk(clk), .rst(rst), .mode_pkt(mode_pkt), .level3_sel(level3_sel),
    .port_addr(port_addr), .poll_addr(poll_addr), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .pkt_need(pkt_need), .space_ok(space_ok), .space_oe(space_oe)
  );

  // Behavioural reference: byte count plus a short history of poll hits.
  int m_occ = 0;
  bit hist[$] = '{1'b0, 1'b0};

  always @(posedge clk) begin
    if (rst) begin
      m_occ = 0;
      hist = '{1'b0, 1'b0};
    end else begin
      if (wr_byte && !rd_byte && m_occ < DEPTH) m_occ++;
      else if (rd_byte && !wr_byte && m_occ > 0) m_occ--;
      hist.push_front(poll_addr == port_addr && poll_addr != 5'h1F);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      int need;
      bit exp_ok, exp_oe, slow;
      need   = mode_pkt ? int'(pkt_need) : CELL;
      exp_ok = (DEPTH - m_occ) >= need;
      slow   = mode_pkt && level3_sel;
      exp_oe = slow ? hist[1] : hist[0];
      check(space_ok, exp_ok, mode_pkt ? "R5" : "R4");
      check(space_oe, exp_oe, slow ? "R8" : "R7");
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic poll_seq();
    poll_addr = port_addr; cyc(3);
    poll_addr = 5'd3;      cyc(3);
    poll_addr = port_addr; cyc(1);
    poll_addr = 5'd9;      cyc(1);
    poll_addr = port_addr; cyc(2);
    poll_addr = 5'h1F;     cyc(3);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    live = 1'b1;
    @(negedge clk);
    scen = "R1";
    check(space_oe, 1'b0, "R1");
    check(space_ok, 1'b1, "R1");
    cyc(1);

    scen = "R6"; poll_seq();
    scen = "R7"; poll_seq();

    scen = "R2"; wr_byte = 1'b1; cyc(210); wr_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b0, "R4");
    cyc(1);
    rd_byte = 1'b1; cyc(7); rd_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b1, "R4");
    cyc(1);
    wr_byte = 1'b1; rd_byte = 1'b1; cyc(20); wr_byte = 1'b0; rd_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b1, "R2");
    cyc(1);

    scen = "R5"; mode_pkt = 1'b1; pkt_need = OCC_W'(100); cyc(2);
    pkt_need = OCC_W'(53); cyc(1);
    pkt_need = OCC_W'(54); cyc(1);
    scen = "R7"; level3_sel = 1'b0; poll_seq();
    scen = "R8"; level3_sel = 1'b1; poll_seq();
    poll_addr = port_addr; cyc(1); level3_sel = 1'b0; cyc(1); level3_sel = 1'b1; cyc(2);
    mode_pkt = 1'b0; cyc(2); mode_pkt = 1'b1; cyc(2);

    scen = "R3"; wr_byte = 1'b1; cyc(300); wr_byte = 1'b0;
    pkt_need = OCC_W'(1); cyc(1);
    @(negedge clk); check(space_ok, 1'b0, "R3");
    cyc(1);
    wr_byte = 1'b1; rd_byte = 1'b1; cyc(5); wr_byte = 1'b0; rd_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b0, "R2");
    cyc(1);
    rd_byte = 1'b1; cyc(1); rd_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b1, "R3");
    cyc(1);
    rd_byte = 1'b1; cyc(300); rd_byte = 1'b0;
    pkt_need = OCC_W'(256); cyc(1);
    wr_byte = 1'b1; cyc(1); wr_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b0, "R3");
    cyc(1);
    rd_byte = 1'b1; cyc(1); rd_byte = 1'b0;
    @(negedge clk); check(space_ok, 1'b1, "R3");
    cyc(1);

    scen = "R6"; port_addr = 5'h1F; poll_addr = 5'h1F; cyc(4);
    @(negedge clk); check(space_oe, 1'b0, "R6");
    cyc(1);
    port_addr = 5'd12;

    scen = "mix";
    for (int i = 0; i < 600; i++) begin
      wr_byte    = ($urandom % 3) != 0;
      rd_byte    = ($urandom % 2) != 0;
      poll_addr  = ($urandom % 3 == 0) ? port_addr : 5'($urandom);
      if (i % 97 == 0) begin
        mode_pkt   = $urandom % 2;
        level3_sel = $urandom % 2;
        pkt_need   = OCC_W'($urandom % (DEPTH + 1));
      end
      cyc(1);
    end
    wr_byte = 1'b0; rd_byte = 1'b0;

    scen = "R1"; rst = 1'b1; cyc(1); rst = 1'b0;
    @(negedge clk);
    check(space_oe, 1'b0, "R1");
    cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired [%s]", scen);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule